// File: doc/BRIEF.md
# RNG Command/Status Controller

This block is the register-facing control plane of a random number generator peripheral. Software reaches it over a simple 32-bit read/write bus with a single-cycle strobe and reads back the result one cycle later. It can start a seeding job or a self-test job with write-one command bits. It keeps a sticky error register and done flags, and it drives a level interrupt that is masked per source. Once a seed has completed cleanly, it keeps a small output word FIFO topped up.

Generated words come from a 32-bit LFSR stand-in. The seeding and self-test jobs are modelled by fixed-length countdowns. A test input forces a statistical failure at the end of a seed, so that the software retry path can be exercised. With automatic reseeding enabled, the block starts a new seed by itself once a programmable number of words has been produced since the last seed started.

Top module: `rng_ctrl_top`

## Requirements
- R1: A read of word offset 0x00 returns {TYPE_CODE[3:0] in bits 31:28, zero in 27:16, REV_MAJOR in 15:8, REV_MINOR in 7:0}. With the defaults this is 0x20000103.
- R2: After reset, status (0x0C), error (0x10) and control (0x08) read as zero, irq is low, and the command offset (0x04) reads as zero.
- R3: Writing 1 to command bit 1 (seed) or bit 0 (self-test) starts a job while none is running. Seed-done (status bit 5) or test-done (status bit 4) is set on the clock edge SEED_CYCLES or TEST_CYCLES edges after the write edge. A start command written while a job runs is ignored.
- R4: If test_force_stat_err is high when a seed completes, the error register gets code 0x8, status bit 16 and seed-done are set, and the FIFO is no longer refilled. A later seed that completes without the force clears the block back to a seeded state and refill resumes.
- R5: After a clean seed, one word per clock is pushed into the FIFO (FIFO_DEPTH = 15), starting the edge after completion, until the FIFO is full. Refilling pauses while any job runs. Status bits 11:8 show the fill level.
- R6: Each read of offset 0x14 from a non-empty FIFO pops one word and lowers the level by one. Words come out in the LFSR order: the first word is LFSR_INIT, and each next word is (s >> 1) ^ (s[0] ? LFSR_TAPS : 0).
- R7: A read of 0x14 from an empty FIFO returns 0 and ORs code 0x4 into the error register, which raises status bit 16.
- R8: irq = ((seed-done or test-done) and not control bit 5) or (error register nonzero and not control bit 6).
- R9: Command bit 4 (clear interrupt) clears both done flags only when the error register is zero. While an error is pending it has no effect.
- R10: Command bit 5 (clear error) zeroes the error register and clears both done flags.
- R11: With control bit 4 set, a seed starts by itself on the first idle edge once RESULTS_PER_SEED*WORDS_PER_RESULT words have been pushed since the last seed started. With bit 4 clear, no automatic seed ever starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| test_force_stat_err | input | 1 | Forces a statistical failure at seed completion |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is registered, so a value is sampled one cycle after its strobe and reflects the state before that edge. A done bit therefore first shows on the read sampled one edge after the job's completion edge. The first refilled word shows in the level one read later again. Irq is combinational from registered flags and is correct from the cycle after the write that changes a mask or flag. The bench's reference model steps once per rising edge and is compared on every falling edge. Its directed reads are placed at exactly these edges: just before and just after each completion, so that both off-by-one directions are caught.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
    // register word indices (byte address bits 4:2)
    localparam logic [2:0] IDX_VERSION = 3'd0;
    localparam logic [2:0] IDX_COMMAND = 3'd1;
    localparam logic [2:0] IDX_CONTROL = 3'd2;
    localparam logic [2:0] IDX_STATUS  = 3'd3;
    localparam logic [2:0] IDX_ERROR   = 3'd4;
    localparam logic [2:0] IDX_FIFO    = 3'd5;

    // command bits (write-one actions)
    localparam int CMD_SELFTEST = 0;
    localparam int CMD_SEED     = 1;
    localparam int CMD_CLR_IRQ  = 4;
    localparam int CMD_CLR_ERR  = 5;

    // control bits
    localparam int CTL_AUTO      = 4;
    localparam int CTL_MASK_DONE = 5;
    localparam int CTL_MASK_ERR  = 6;

    // status fields
    localparam int STS_TEST_DONE = 4;
    localparam int STS_SEED_DONE = 5;
    localparam int STS_LEVEL_LSB = 8;
    localparam int STS_LEVEL_W   = 4;
    localparam int STS_ERROR     = 16;

    // error codes
    localparam logic [31:0] ERRC_UNDERFLOW = 32'h0000_0004;
    localparam logic [31:0] ERRC_STAT      = 32'h0000_0008;

    typedef enum logic [1:0] {
        JOB_IDLE = 2'd0,
        JOB_SEED = 2'd1,
        JOB_TEST = 2'd2
    } job_e;
endpackage

// File: rtl/rng_ctrl_lfsr.sv
module rng_ctrl_lfsr #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   INIT = 32'h1D2C_3B4A,
    parameter logic [W-1:0]   TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INIT;
        else        state_q <= state_d;
    end

    assign word_o = state_q;

    // R6: a Galois LFSR that starts nonzero can never reach the all-zero lockup state
    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/rng_ctrl_fifo.sv
module rng_ctrl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 15,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] lvl;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (push_i) p_d.wr = wrap_inc(p_q.wr);
        if (pop_i)  p_d.rd = wrap_inc(p_q.rd);
        case ({push_i, pop_i})
            2'b10:   p_d.lvl = p_q.lvl + 1'b1;
            2'b01:   p_d.lvl = p_q.lvl - 1'b1;
            default: p_d.lvl = p_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[p_q.wr] <= wdata_i;
    end

    assign head_o  = mem[p_q.rd];
    assign level_o = p_q.lvl;
    assign full_o  = (p_q.lvl == LVL_W'(DEPTH));
    assign empty_o = (p_q.lvl == '0);

    // R5: the refill logic upstream never pushes into a full FIFO
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R7: empty reads are turned into underflow errors upstream, never pops
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/rng_ctrl_seq.sv
module rng_ctrl_seq
    import rng_ctrl_pkg::*;
#(
    parameter int SEED_CYCLES = 24,
    parameter int TEST_CYCLES = 16,
    localparam int MAX_CYC = (SEED_CYCLES > TEST_CYCLES) ? SEED_CYCLES : TEST_CYCLES,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_req_i,
    input  logic test_req_i,
    input  logic stat_fail_i,
    output logic busy_o,
    output logic seed_accept_o,
    output logic seed_fin_o,
    output logic seed_fail_o,
    output logic test_fin_o
);
    typedef struct packed {
        job_e             job;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic fin;

    always_comb begin
        s_d = s_q;
        fin = (s_q.job != JOB_IDLE) && (s_q.cnt == '0);
        if (s_q.job == JOB_IDLE) begin
            if (seed_req_i) begin
                s_d.job = JOB_SEED;
                s_d.cnt = CNT_W'(SEED_CYCLES - 1);
            end else if (test_req_i) begin
                s_d.job = JOB_TEST;
                s_d.cnt = CNT_W'(TEST_CYCLES - 1);
            end
        end else if (fin) begin
            s_d.job = JOB_IDLE;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{job: JOB_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy_o        = (s_q.job != JOB_IDLE);
    assign seed_accept_o = (s_q.job == JOB_IDLE) && seed_req_i;
    assign seed_fin_o    = fin && (s_q.job == JOB_SEED);
    assign seed_fail_o   = fin && (s_q.job == JOB_SEED) && stat_fail_i;
    assign test_fin_o    = fin && (s_q.job == JOB_TEST);

    // R3: an accepted seed loads the full seed length on the next cycle
    p_seed_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_accept_o |=> (s_q.job == JOB_SEED && s_q.cnt == CNT_W'(SEED_CYCLES - 1)));
    // R3: a running job keeps its kind until its own completion, whatever is requested
    p_busy_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fin) |=> $stable(s_q.job));
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
    import rng_ctrl_pkg::*;
#(
    parameter logic [3:0]  TYPE_CODE        = 4'h2,
    parameter logic [7:0]  REV_MAJOR        = 8'h01,
    parameter logic [7:0]  REV_MINOR        = 8'h03,
    parameter int          FIFO_DEPTH       = 15,
    parameter int          SEED_CYCLES      = 24,
    parameter int          TEST_CYCLES      = 16,
    parameter int          RESULTS_PER_SEED = 1 << 20,
    parameter int          WORDS_PER_RESULT = 5,
    parameter logic [31:0] LFSR_INIT        = 32'h1D2C_3B4A,
    parameter logic [31:0] LFSR_TAPS        = 32'h8020_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        test_force_stat_err,
    output logic        irq
);
    localparam int          GEN_LIMIT    = RESULTS_PER_SEED * WORDS_PER_RESULT;
    localparam int          GEN_W        = $clog2(GEN_LIMIT + 1);
    localparam int          LVL_W        = $clog2(FIFO_DEPTH + 1);
    localparam logic [31:0] VERSION_WORD = {TYPE_CODE, 12'h000, REV_MAJOR, REV_MINOR};

    typedef struct packed {
        logic [31:0]      err;
        logic             seed_done;
        logic             test_done;
        logic             mask_err;
        logic             mask_done;
        logic             auto_en;
        logic             seeded;
        logic [GEN_W-1:0] gen;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]       idx;
    logic             rd_acc, wr_acc, cmd_wr;
    logic             err_pend, done_pend, reseed_req;
    logic             push, pop, underflow;
    logic             busy, seed_accept, seed_fin, seed_fail, test_fin;
    logic             seed_req, test_req;
    logic [31:0]      lfsr_word, head;
    logic [LVL_W-1:0] level;
    logic             full, empty;
    logic [31:0]      status_w, ctrl_w;
    logic             unused_bits;

    assign idx        = bus_addr[4:2];
    assign rd_acc     = bus_en && !bus_we;
    assign wr_acc     = bus_en && bus_we;
    assign cmd_wr     = wr_acc && (idx == IDX_COMMAND);
    assign err_pend   = (r_q.err != '0);
    assign done_pend  = r_q.seed_done || r_q.test_done;
    assign reseed_req = r_q.auto_en && (r_q.gen >= GEN_W'(GEN_LIMIT));
    assign push       = r_q.seeded && !busy && !full && !reseed_req;
    assign pop        = rd_acc && (idx == IDX_FIFO) && !empty;
    assign underflow  = rd_acc && (idx == IDX_FIFO) && empty;
    assign seed_req   = (cmd_wr && bus_wdata[CMD_SEED]) || reseed_req;
    assign test_req   = cmd_wr && bus_wdata[CMD_SELFTEST];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:7], bus_wdata[3:2]};

    rng_ctrl_seq #(
        .SEED_CYCLES (SEED_CYCLES),
        .TEST_CYCLES (TEST_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .seed_req_i    (seed_req),
        .test_req_i    (test_req),
        .stat_fail_i   (test_force_stat_err),
        .busy_o        (busy),
        .seed_accept_o (seed_accept),
        .seed_fin_o    (seed_fin),
        .seed_fail_o   (seed_fail),
        .test_fin_o    (test_fin)
    );

    rng_ctrl_lfsr #(
        .W    (32),
        .INIT (LFSR_INIT),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (push),
        .word_o (lfsr_word)
    );

    rng_ctrl_fifo #(
        .W     (32),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .wdata_i (lfsr_word),
        .pop_i   (pop),
        .head_o  (head),
        .level_o (level),
        .full_o  (full),
        .empty_o (empty)
    );

    always_comb begin
        status_w = '0;
        status_w[STS_ERROR] = err_pend;
        status_w[STS_LEVEL_LSB +: STS_LEVEL_W] = STS_LEVEL_W'(level);
        status_w[STS_SEED_DONE] = r_q.seed_done;
        status_w[STS_TEST_DONE] = r_q.test_done;
        ctrl_w = '0;
        ctrl_w[CTL_MASK_ERR]  = r_q.mask_err;
        ctrl_w[CTL_MASK_DONE] = r_q.mask_done;
        ctrl_w[CTL_AUTO]      = r_q.auto_en;
    end

    always_comb begin
        r_d = r_q;
        // read port
        if (rd_acc) begin
            case (idx)
                IDX_VERSION: r_d.rdata = VERSION_WORD;
                IDX_CONTROL: r_d.rdata = ctrl_w;
                IDX_STATUS:  r_d.rdata = status_w;
                IDX_ERROR:   r_d.rdata = r_q.err;
                IDX_FIFO:    r_d.rdata = empty ? '0 : head;
                default:     r_d.rdata = '0;
            endcase
        end
        // clears first, new events afterwards
        if (cmd_wr && bus_wdata[CMD_CLR_ERR]) begin
            r_d.err       = '0;
            r_d.seed_done = 1'b0;
            r_d.test_done = 1'b0;
        end else if (cmd_wr && bus_wdata[CMD_CLR_IRQ] && !err_pend) begin
            r_d.seed_done = 1'b0;
            r_d.test_done = 1'b0;
        end
        if (underflow) r_d.err = r_d.err | ERRC_UNDERFLOW;
        if (seed_fail) r_d.err = r_d.err | ERRC_STAT;
        if (seed_fin) begin
            r_d.seed_done = 1'b1;
            r_d.seeded    = !seed_fail;
        end
        if (test_fin) r_d.test_done = 1'b1;
        // control register
        if (wr_acc && (idx == IDX_CONTROL)) begin
            r_d.mask_err  = bus_wdata[CTL_MASK_ERR];
            r_d.mask_done = bus_wdata[CTL_MASK_DONE];
            r_d.auto_en   = bus_wdata[CTL_AUTO];
        end
        // words produced since the last seed start, saturating at the limit
        if (seed_accept) begin
            r_d.gen = '0;
        end else if (push && (r_q.gen < GEN_W'(GEN_LIMIT))) begin
            r_d.gen = r_q.gen + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq = (done_pend && !r_q.mask_done) || (err_pend && !r_q.mask_err);

    // R10: a clear-error write with no competing event leaves nothing pending
    p_clr_err_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_CLR_ERR] && !seed_fin && !test_fin)
        |=> (r_q.err == '0 && !r_q.seed_done && !r_q.test_done));
    // R9: a plain interrupt clear cannot drop a done flag while an error is pending
    p_clr_irq_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_CLR_IRQ] && !bus_wdata[CMD_CLR_ERR] && err_pend && r_q.seed_done)
        |=> r_q.seed_done);
    // R7: an empty read returns zero and records the underflow code
    p_underflow_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (r_q.err[2] && bus_rdata == '0));
    // R4: a failed seed stops refill until a clean seed
    p_fail_stops_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_fail |=> (!r_q.seeded && r_q.err[3]));
    // R11: with auto reseed off the sequencer only starts a seed on a command
    p_no_auto_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_accept && !r_q.auto_en) |-> (cmd_wr && bus_wdata[CMD_SEED]));
endmodule

// File: tb/tb_rng_ctrl_top.sv
module tb_rng_ctrl_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          SC         = 24;
    localparam int          TC         = 16;
    localparam int          DEPTH      = 15;
    localparam int          LIMIT      = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [31:0] INIT       = 32'h1D2C_3B4A;
    localparam logic [31:0] TAPS       = 32'h8020_0003;
    localparam logic [4:0]  A_VER = 5'h00, A_CMD = 5'h04, A_CTL = 5'h08,
                            A_STS = 5'h0C, A_ERR = 5'h10, A_FIFO = 5'h14;

    logic        clk, rst_n, bus_en, bus_we, force_err, irq;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [31:0] exp_lfsr = INIT;
    logic [31:0] d;

    rng_ctrl_top #(
        .SEED_CYCLES      (SC),
        .TEST_CYCLES      (TC),
        .FIFO_DEPTH       (DEPTH),
        .RESULTS_PER_SEED (2),
        .WORDS_PER_RESULT (5),
        .LFSR_INIT        (INIT),
        .LFSR_TAPS        (TAPS)
    ) dut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .bus_en              (bus_en),
        .bus_we              (bus_we),
        .bus_addr            (bus_addr),
        .bus_wdata           (bus_wdata),
        .bus_rdata           (bus_rdata),
        .test_force_stat_err (force_err),
        .irq                 (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_q[$];
    logic [31:0] m_err, m_rdata, m_lfsr;
    bit          m_sd, m_td, m_me, m_md, m_auto, m_seeded, m_rdv;
    int          m_job, m_cnt, m_gen, m_ridx;
    bit          t_rd, t_wr, t_cmd, t_fin, t_fail, t_reseed, t_push, t_pop, t_under, t_acc, t_errp;
    int          t_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_err = 0; m_rdata = 0; m_lfsr = INIT;
            m_sd = 0; m_td = 0; m_me = 0; m_md = 0; m_auto = 0; m_seeded = 0; m_rdv = 0;
            m_job = 0; m_cnt = 0; m_gen = 0; m_ridx = 0;
        end else begin
            t_rd     = bus_en && !bus_we;
            t_wr     = bus_en && bus_we;
            t_idx    = int'(bus_addr[4:2]);
            t_cmd    = t_wr && t_idx == 1;
            t_errp   = (m_err != 0);
            t_fin    = (m_job != 0) && (m_cnt == 0);
            t_fail   = t_fin && m_job == 1 && force_err;
            t_reseed = m_auto && m_gen >= LIMIT;
            t_push   = m_seeded && m_job == 0 && m_q.size() < DEPTH && !t_reseed;
            t_pop    = t_rd && t_idx == 5 && m_q.size() > 0;
            t_under  = t_rd && t_idx == 5 && m_q.size() == 0;
            t_acc    = (m_job == 0) && ((t_cmd && bus_wdata[1]) || t_reseed);
            m_rdv    = t_rd;
            if (t_rd) begin
                m_ridx = t_idx;
                case (t_idx)
                    0: m_rdata = 32'h2000_0103;
                    2: m_rdata = {25'b0, m_me, m_md, m_auto, 4'b0};
                    3: m_rdata = {15'b0, t_errp, 4'b0, 4'(m_q.size()), 2'b0, m_sd, m_td, 4'b0};
                    4: m_rdata = m_err;
                    5: m_rdata = t_pop ? m_q[0] : 32'h0;
                    default: m_rdata = 32'h0;
                endcase
            end
            if (t_cmd && bus_wdata[5]) begin
                m_err = 0; m_sd = 0; m_td = 0;
            end else if (t_cmd && bus_wdata[4] && !t_errp) begin
                m_sd = 0; m_td = 0;
            end
            if (t_under) m_err = m_err | 32'h4;
            if (t_fail)  m_err = m_err | 32'h8;
            if (t_fin && m_job == 1) begin m_sd = 1; m_seeded = !t_fail; end
            if (t_fin && m_job == 2) m_td = 1;
            if (t_wr && t_idx == 2) begin
                m_me = bus_wdata[6]; m_md = bus_wdata[5]; m_auto = bus_wdata[4];
            end
            if (t_pop) void'(m_q.pop_front());
            if (t_push) begin m_q.push_back(m_lfsr); m_lfsr = lfsr_next(m_lfsr); end
            if (t_acc) m_gen = 0;
            else if (t_push && m_gen < LIMIT) m_gen++;
            if (m_job == 0) begin
                if (t_acc) begin m_job = 1; m_cnt = SC - 1; end
                else if (t_cmd && bus_wdata[0]) begin m_job = 2; m_cnt = TC - 1; end
            end else if (m_cnt == 0) m_job = 0;
            else m_cnt--;
        end
    end

    function automatic string reg_tag(input int i);
        case (i)
            0: return "R1 version read";
            2: return "R8 control read";
            3: return "R5 status read";
            4: return "R7 error read";
            5: return "R6 fifo read";
            default: return "R2 command read";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 irq vs model", {31'b0, irq},
                  {31'b0, ((m_sd || m_td) && !m_md) || (m_err != 0 && !m_me)});
            if (m_rdv) check(reg_tag(m_ridx), bus_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_fail++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG - 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_word(input string tag);
        logic [31:0] w;
        rd(A_FIFO, w);
        check(tag, w, exp_lfsr);
        exp_lfsr = lfsr_next(exp_lfsr);
    endtask

    initial begin
        rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; force_err = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R2 reset state, R1 version
        check("R2 irq after reset", {31'b0, irq}, 32'h0);
        rd(A_STS, d); check("R2 status after reset", d, 32'h0);
        rd(A_ERR, d); check("R2 error after reset", d, 32'h0);
        rd(A_CTL, d); check("R2 control after reset", d, 32'h0);
        rd(A_CMD, d); check("R2 command reads zero", d, 32'h0);
        rd(A_VER, d); check("R1 version word", d, 32'h2000_0103);

        // R7 underflow, R8 masking, R9 blocked clear, R10 clear error
        rd(A_FIFO, d); check("R7 empty read value", d, 32'h0);
        rd(A_ERR, d);  check("R7 underflow code", d, 32'h4);
        rd(A_STS, d);  check("R7 status error bit", d, 32'h0001_0000);
        check("R8 irq on error", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h40); check("R8 error masked", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h00); check("R8 error unmasked", {31'b0, irq}, 32'h1);
        wr(A_CMD, 32'h10);
        rd(A_ERR, d); check("R9 clear-int ignored on error", d, 32'h4);
        wr(A_CMD, 32'h20);
        rd(A_ERR, d); check("R10 clear-error zeroes", d, 32'h0);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R3 seed timing, R5 refill start, R8 done mask
        wr(A_CTL, 32'h20);
        wr(A_CMD, 32'h02);
        idle(SC - 1);
        rd(A_STS, d); check("R3 seed not done yet", d, 32'h0);
        rd(A_STS, d); check("R3 seed done on time", d, 32'h20);
        rd(A_STS, d); check("R5 first word pushed", d, 32'h120);
        check("R8 done masked", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h00); check("R8 done unmasked", {31'b0, irq}, 32'h1);
        wr(A_CMD, 32'h10); check("R9 clear-int drops irq", {31'b0, irq}, 32'h0);
        idle(20);
        rd(A_STS, d); check("R5 fifo full level", d, 32'hF00);

        // R6 word order and level decrement
        rd_word("R6 word 0");
        rd(A_STS, d); check("R6 level lowered", d, 32'hE00);
        rd_word("R6 word 1");
        rd_word("R6 word 2");
        idle(2);

        // R3 self-test timing, R5 pause, R3 start ignored while busy
        wr(A_CMD, 32'h01);
        rd_word("R6 word during test");
        rd(A_STS, d); check("R5 no refill while busy", d, 32'hE00);
        wr(A_CMD, 32'h02);
        idle(TC - 4);
        rd(A_STS, d); check("R3 test not done yet", d, 32'hE00);
        rd(A_STS, d); check("R3 test done on time", d, 32'hE10);
        rd(A_STS, d); check("R5 refill resumes", d, 32'hF10);
        check("R8 irq on test done", {31'b0, irq}, 32'h1);
        idle(SC + 5);
        rd(A_STS, d); check("R3 seed during test ignored", d, 32'hF10);
        wr(A_CMD, 32'h10);
        rd(A_STS, d); check("R9 clear-int clears test done", d, 32'hF00);

        // R4 forced statistical failure and retry
        force_err = 1;
        wr(A_CMD, 32'h02);
        idle(SC);
        rd(A_STS, d); check("R4 failed seed status", d, 32'h0001_0F20);
        rd(A_ERR, d); check("R4 stat error code", d, 32'h8);
        rd_word("R6 word after fail");
        idle(3);
        rd(A_STS, d); check("R4 refill stopped", d, 32'h0001_0E20);
        wr(A_CMD, 32'h10);
        rd(A_ERR, d); check("R9 clear-int blocked error", d, 32'h8);
        rd(A_STS, d); check("R9 done kept under error", d, 32'h0001_0E20);
        force_err = 0;
        wr(A_CMD, 32'h20);
        rd(A_STS, d); check("R10 clear-error clears all", d, 32'hE00);
        wr(A_CMD, 32'h02);
        idle(SC + 3);
        rd(A_STS, d); check("R4 retry seeds and refills", d, 32'hF20);
        rd(A_ERR, d); check("R4 retry error free", d, 32'h0);
        wr(A_CMD, 32'h10);

        // R11 auto reseed off then on
        for (int i = 0; i < 12; i++) rd_word("R6 drain word");
        idle(40);
        rd(A_STS, d); check("R11 no reseed when off", d, 32'hF00);
        wr(A_CTL, 32'h10);
        idle(SC);
        rd(A_STS, d); check("R11 auto seed not done yet", d, 32'hF00);
        rd(A_STS, d); check("R11 auto seed done", d, 32'hF20);
        rd_word("R6 word after auto seed");
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule